// File: doc/BRIEF.md
# SPI Master Shift Engine with External Clock Option

This block is a full-duplex serial shift engine for the controller side of an SPI link. Software reaches it through three registers on a simple synchronous bus: a control register, a status register and a data register. A write to the data register starts a transfer of 8 or 16 bits. Bits leave on the serial data output, most significant bit first, while bits arrive on the serial data input. At the end of the transfer the received word is stored in a receive buffer and a completion flag is raised.

The serial clock normally comes from the system clock through a programmable divider. The clock's idle level, the edge on which output data changes and the point at which input data is sampled are all programmable. A control bit switches the engine to shift on transitions that an external source drives onto the clock pin. In that mode the divider is held idle and the engine stops driving the pin. A second control bit releases the data output pin. A receive overflow is flagged when a word completes while the previous one is still unread.

Register map (word addresses): 0 = control, 1 = status, 2 = data. Control fields: bit 12 external clock, bit 11 data output release, bit 10 word size, bit 9 late sample, bit 8 output on trailing edge, bit 6 clock polarity, bit 5 master, bit 4 interrupt enable, bits 3:0 divider. Status fields: bit 15 enable, bit 6 overflow, bit 2 busy, bit 1 done, bit 0 receive full.

Top module: `spi_xclk_master`

## Requirements
- R1: A write to address 2 starts a transfer only when status bit 15 (enable) and control bit 5 (master) are both set and no transfer is running; otherwise no clock edges appear and status bit 2 (busy) stays 0.
- R2: Control bit 10 set gives a 16-bit transfer of data bits 15:0; clear gives an 8-bit transfer of bits 7:0, and the received byte reads back in bits 7:0 with bits 15:8 zero. Bits go most significant first in both sizes.
- R3: Control bit 6 gives the serial clock's idle level: with 0 the clock idles low and pulses high, with 1 it idles high and pulses low. A transfer of N bits produces exactly 2N clock transitions and returns the clock to its idle level.
- R4: Control bit 8 at 0 makes output data change on idle-to-active transitions. At 1 the first bit is driven from the start and later bits change on active-to-idle transitions. In both cases a receiver that samples on the other kind of transition sees the transmitted word.
- R5: Control bit 9 at 0 samples input at the middle of each bit time, that is on the transition opposite to the output change. At 1 it samples at the end of the bit time. Either way a peer that changes its data on the output-change transitions is received correctly. With internal clocking, bit 8 at 0 and bit 9 at 1, one extra half period follows the last transition to sample the final bit. With an external clock that final bit is sampled on the last transition.
- R6: With internal clocking, control bits 3:0 hold a value D, and each half period of the serial clock lasts D+1 system clock cycles.
- R7: Control bit 12 set stops the engine from driving the clock pin (sck_oe low), holds the divider idle, and advances the transfer one step per transition of sck_i. The transfer result is the same as with internal clocking.
- R8: sdo_oe is high exactly when the block is enabled, in master mode and control bit 11 is clear.
- R9: Clearing status bit 15 aborts any transfer at once; out of reset every register reads 0 and no pin is driven.
- R10: Status bit 6 (overflow) sets when a transfer completes while bit 0 is still set. The new word is then discarded, so the buffer keeps the older one. The flag clears only when software writes 0 to bit 6.
- R11: Status bit 0 (receive full) sets on completion and clears when address 2 is read.
- R12: Status bit 1 (done) sets on completion and clears only when software writes 0 to it; irq_o is high while bit 1 and control bit 4 are both set.
- R13: Status bit 2 (busy) is high for the whole transfer, and a write to address 2 while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading data clears receive full) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock pin input, used in external clock mode |
| sck_o | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out drive enable |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit long word, an 8-bit short word and a two-stage synchronizer on the external clock. With these values both word sizes, all eight combinations of polarity, output edge and sample point, and divider values from 0 to 7 can be reached in short runs. The two-stage synchronizer puts the external clock path's latency well inside the twelve-cycle edge spacing that the bench's peer model uses. A behavioural peer changes its data on the output-change transitions, after a delay in external mode. This exposes the end-of-bit sampling corner and the extra trailing half period.

// File: rtl/spi_xclk_pkg.sv
package spi_xclk_pkg;
   localparam int BUS_W  = 16;
   localparam int CDIV_W = 4;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   // control field positions
   localparam int C_EXT    = 12;
   localparam int C_SDOREL = 11;
   localparam int C_WIDE   = 10;
   localparam int C_CAPLT  = 9;
   localparam int C_TRAIL  = 8;
   localparam int C_CPOL   = 6;
   localparam int C_MASTER = 5;
   localparam int C_IRQEN  = 4;

   // status field positions
   localparam int S_EN   = 15;
   localparam int S_OVF  = 6;
   localparam int S_BUSY = 2;
   localparam int S_DONE = 1;
   localparam int S_RXF  = 0;

   typedef struct packed {
      logic              ext_clk;
      logic              sdo_rel;
      logic              wide;
      logic              cap_late;
      logic              out_trail;
      logic              cpol;
      logic              master;
      logic              irq_en;
      logic [CDIV_W-1:0] div;
   } cfg_t;
endpackage

// File: rtl/spi_xclk_regs.sv
module spi_xclk_regs
   import spi_xclk_pkg::*;
#(
   parameter int LONG_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              busy,
   input  logic              complete,
   input  logic [LONG_W-1:0] rx_word,
   output cfg_t              cfg,
   output logic              enable,
   output logic              start,
   output logic              ovf,
   output logic              done,
   output logic              rxf,
   output logic              irq
);
   logic [BUS_W-1:0]  ctrl_q;
   logic [LONG_W-1:0] rxbuf_q;
   logic              wr_ctrl, wr_stat, wr_data, rd_data, accept;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_data = bus_wr && (bus_addr == A_DATA);
   assign rd_data = bus_rd && (bus_addr == A_DATA);
   // a read in the completion cycle frees the buffer for the new word
   assign accept  = !rxf || rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         enable  <= 1'b0;
         ovf     <= 1'b0;
         done    <= 1'b0;
         rxf     <= 1'b0;
         rxbuf_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (wr_stat) begin
            enable <= bus_wdata[S_EN];
            if (!bus_wdata[S_OVF])  ovf  <= 1'b0;
            if (!bus_wdata[S_DONE]) done <= 1'b0;
         end
         if (rd_data) rxf <= 1'b0;
         if (complete) begin
            done <= 1'b1;
            if (accept) begin
               rxbuf_q <= rx_word;
               rxf     <= 1'b1;
            end else begin
               ovf <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      cfg.ext_clk   = ctrl_q[C_EXT];
      cfg.sdo_rel   = ctrl_q[C_SDOREL];
      cfg.wide      = ctrl_q[C_WIDE];
      cfg.cap_late  = ctrl_q[C_CAPLT];
      cfg.out_trail = ctrl_q[C_TRAIL];
      cfg.cpol      = ctrl_q[C_CPOL];
      cfg.master    = ctrl_q[C_MASTER];
      cfg.irq_en    = ctrl_q[C_IRQEN];
      cfg.div       = ctrl_q[CDIV_W-1:0];
   end

   assign start = wr_data && enable && cfg.master && !busy;
   assign irq   = done && cfg.irq_en;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: bus_rdata = ctrl_q;
         A_STAT: begin
            bus_rdata[S_EN]   = enable;
            bus_rdata[S_OVF]  = ovf;
            bus_rdata[S_BUSY] = busy;
            bus_rdata[S_DONE] = done;
            bus_rdata[S_RXF]  = rxf;
         end
         A_DATA: bus_rdata = BUS_W'(rxbuf_q);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_xclk_tick.sv
module spi_xclk_tick
   import spi_xclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ext_sel,
   input  logic [CDIV_W-1:0] div,
   input  logic              sck_i,
   output logic              tick
);
   logic [CDIV_W-1:0] cnt_q;
   logic              sync_q [SYNC_STAGES];
   logic              prev_q;
   logic              tick_int, tick_ext;

   // internal divider, parked at zero while idle or externally clocked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!run || ext_sel)   cnt_q <= '0;
      else if (cnt_q == div)      cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
   assign tick_int = run && !ext_sel && (cnt_q == div);

   // synchronizer chain for the external clock pin
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sck_i;
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];

   assign tick_ext = run && ext_sel && (sync_q[SYNC_STAGES-1] != prev_q);
   assign tick     = tick_int || tick_ext;
endmodule

// File: rtl/spi_xclk_shift.sv
module spi_xclk_shift
   import spi_xclk_pkg::*;
#(
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic              tick,
   input  cfg_t              cfg,
   input  logic [LONG_W-1:0] tx_in,
   input  logic              sdi,
   output logic              busy,
   output logic              shifting,
   output logic              complete,
   output logic [LONG_W-1:0] rx_word,
   output logic              sck_lvl,
   output logic              sdo
);
   localparam int CNT_W = $clog2(2 * LONG_W + 2);

   logic [LONG_W-1:0] tx_q, rx_q, tx_load;
   logic [CNT_W-1:0]  tcnt_q, capcnt_q, t_now, nbits, twice, last_t, c0, s0;
   logic              fin_q, ph_q, tail, cap, shf, tog;

   assign nbits  = cfg.wide ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
   assign twice  = nbits << 1;
   assign tail   = !cfg.out_trail && cfg.cap_late && !cfg.ext_clk;
   assign last_t = twice + CNT_W'(tail);
   assign t_now  = tcnt_q + 1'b1;
   // first capture transition and first output-change transition
   assign c0 = cfg.out_trail ? (cfg.cap_late ? CNT_W'(2) : CNT_W'(1))
                             : (cfg.cap_late ? CNT_W'(3) : CNT_W'(2));
   assign s0 = cfg.out_trail ? CNT_W'(2) : CNT_W'(3);

   assign tog = (t_now <= twice);
   assign cap = ((t_now >= c0) && (t_now[0] == c0[0]) && (capcnt_q < nbits))
             || ((t_now == last_t) && (capcnt_q == nbits - 1'b1));
   assign shf = (t_now >= s0) && (t_now[0] == s0[0]) && (t_now < twice);

   if (SHORT_W < LONG_W) begin : g_pad
      assign tx_load = cfg.wide ? tx_in
                                : {tx_in[SHORT_W-1:0], {(LONG_W-SHORT_W){1'b0}}};
   end else begin : g_same
      assign tx_load = tx_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         fin_q    <= 1'b0;
         ph_q     <= 1'b0;
         tcnt_q   <= '0;
         capcnt_q <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else if (!enable) begin
         busy  <= 1'b0;
         fin_q <= 1'b0;
         ph_q  <= 1'b0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         fin_q    <= 1'b0;
         ph_q     <= 1'b0;
         tcnt_q   <= '0;
         capcnt_q <= '0;
         tx_q     <= tx_load;
         rx_q     <= '0;
      end else if (fin_q) begin
         busy  <= 1'b0;
         fin_q <= 1'b0;
      end else if (busy && tick) begin
         tcnt_q <= t_now;
         if (tog) ph_q <= ~ph_q;
         if (cap) begin
            rx_q     <= {rx_q[LONG_W-2:0], sdi};
            capcnt_q <= capcnt_q + 1'b1;
         end
         if (shf) tx_q <= {tx_q[LONG_W-2:0], 1'b0};
         if (t_now == last_t) fin_q <= 1'b1;
      end
   end

   assign shifting = busy && !fin_q;
   assign complete = fin_q;
   assign rx_word  = rx_q;
   assign sck_lvl  = cfg.cpol ^ ph_q;
   assign sdo      = tx_q[LONG_W-1];
endmodule

// File: rtl/spi_xclk_master.sv
module spi_xclk_master
   import spi_xclk_pkg::*;
#(
   parameter int LONG_W      = 16,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        sck_i,
   output logic        sck_o,
   output logic        sck_oe,
   output logic        sdo_o,
   output logic        sdo_oe,
   input  logic        sdi_i,
   output logic        irq_o
);
   if (LONG_W > BUS_W || SHORT_W >= LONG_W || SHORT_W < 2) begin : g_bad_width
      $error("spi_xclk_master: need 2 <= SHORT_W < LONG_W <= 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_xclk_master: SYNC_STAGES must be at least 2");
   end

   cfg_t              cfg;
   logic              enable, start, busy, shifting, complete, tick;
   logic              st_ovf, st_done, st_rxf;
   logic [LONG_W-1:0] rx_word;

   spi_xclk_regs #(.LONG_W(LONG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .complete(complete), .rx_word(rx_word), .cfg(cfg),
      .enable(enable), .start(start), .ovf(st_ovf), .done(st_done),
      .rxf(st_rxf), .irq(irq_o)
   );

   spi_xclk_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(shifting), .ext_sel(cfg.ext_clk),
      .div(cfg.div), .sck_i(sck_i), .tick(tick)
   );

   spi_xclk_shift #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .tick(tick),
      .cfg(cfg), .tx_in(bus_wdata[LONG_W-1:0]), .sdi(sdi_i), .busy(busy),
      .shifting(shifting), .complete(complete), .rx_word(rx_word),
      .sck_lvl(sck_o), .sdo(sdo_o)
   );

   assign sck_oe = enable && cfg.master && !cfg.ext_clk;
   assign sdo_oe = enable && cfg.master && !cfg.sdo_rel;
endmodule

// File: rtl/spi_xclk_checker.sv
module spi_xclk_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [1:0]  bus_addr,
   input logic [15:0] bus_wdata,
   input logic        busy,
   input logic        en,
   input logic        ovf,
   input logic        done,
   input logic        rxf,
   input logic        cpol,
   input logic        sck_o
);
   a_r13_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr && bus_addr == 2'd2));

   a_r9_disable_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);

   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(bus_wr && bus_addr == 2'd1 && !bus_wdata[6])) |=> ovf);

   a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(bus_wr && bus_addr == 2'd1 && !bus_wdata[1])) |=> done);

   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd2 && !busy) |=> !rxf);

   a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck_o == cpol));
endmodule

bind spi_xclk_master spi_xclk_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .en(enable),
   .ovf(st_ovf), .done(st_done), .rxf(st_rxf), .cpol(cfg.cpol), .sck_o(sck_o)
);

// File: tb/spi_xclk_master_tb.sv
module spi_xclk_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0, bus_rdata;
   logic        sck_ext = 1'b0, sck_o, sck_oe, sdo_o, sdo_oe, sdi = 1'b0, irq_o;

   int nchk = 0, nfail = 0, cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_xclk_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_i(sck_ext), .sck_o(sck_o), .sck_oe(sck_oe), .sdo_o(sdo_o),
      .sdo_oe(sdo_oe), .sdi_i(sdi), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   always @(posedge clk) if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   // behavioural peer: changes data on output-change transitions, samples the others
   bit          m_on = 0, m_ext = 0, m_trail = 0;
   int          m_nb = 16, m_edges = 0, m_gotn = 0, m_pend = -1, m_pidx = 0, m_t1 = 0, m_t2 = 0;
   logic [15:0] m_sw = 16'h0, m_got = 16'h0;
   logic        m_prev = 1'b0;

   always @(negedge clk) begin
      logic line;
      bit   mid;
      int   idx;
      line = m_ext ? sck_ext : sck_o;
      if (m_pend > 0) m_pend--;
      else if (m_pend == 0) begin sdi = m_sw[m_nb-1-m_pidx]; m_pend = -1; end
      if (m_on && line !== m_prev) begin
         m_edges++;
         if (m_edges == 1) m_t1 = cyc;
         if (m_edges == 2) m_t2 = cyc;
         mid = m_trail ? (m_edges % 2 == 1) : (m_edges % 2 == 0);
         if (mid && m_gotn < m_nb) begin m_got = {m_got[14:0], sdo_o}; m_gotn++; end
         if (!mid) begin
            idx = m_trail ? m_edges / 2 : (m_edges - 1) / 2;
            if (idx < m_nb) begin
               if (m_ext) begin m_pend = 6; m_pidx = idx; end
               else sdi = m_sw[m_nb-1-idx];
            end
         end
      end
      m_prev = line;
   end

   function automatic logic [15:0] mk_ctrl(bit ext, bit rel, bit wide, bit late, bit trail,
                                          bit cpol, bit mst, bit irqen, logic [3:0] div);
      return {3'b000, ext, rel, wide, late, trail, 1'b0, cpol, mst, irqen, div};
   endfunction

   function automatic logic [15:0] size_mask(bit wide, logic [15:0] w);
      return wide ? w : {8'h00, w[7:0]};
   endfunction

   task automatic xfer(input bit cpol, trail, late, wide, ext, input logic [3:0] div,
                       input logic [15:0] tx, sw, input bit irqen, do_read, mid_wr);
      logic [15:0] st, d;
      int          guard;
      string       cfgs;
      cfgs = $sformatf("cpol=%0d trail=%0d late=%0d wide=%0d ext=%0d div=%0d",
                       cpol, trail, late, wide, ext, div);
      sck_ext = cpol;
      wr(2'd0, mk_ctrl(ext, 1'b0, wide, late, trail, cpol, 1'b1, irqen, div));
      wr(2'd1, 16'h8040);
      m_ext = ext; m_trail = trail; m_nb = wide ? 16 : 8; m_sw = sw;
      m_got = 16'h0; m_gotn = 0; m_edges = 0; m_prev = cpol; m_pend = -1;
      sdi = sw[m_nb-1]; m_on = 1;
      wr(2'd2, tx);
      if (mid_wr) begin
         rd(2'd1, st);
         check("R13 busy high during transfer", st[2], 1'b1);
         wr(2'd2, ~tx);
      end
      if (ext) repeat (2 * m_nb) begin
         repeat (12) @(negedge clk);
         sck_ext = ~sck_ext;
      end
      guard = 0;
      do begin rd(2'd1, st); guard++; end while (st[2] && guard < 3000);
      repeat (2) @(negedge clk);
      m_on = 0;
      check({"R4 R2 word seen by peer ", cfgs}, m_got, size_mask(wide, tx));
      check({"R3 transition count ", cfgs}, m_edges, 2 * m_nb);
      check({"R3 clock back at idle ", cfgs}, sck_o, cpol);
      check({"R12 done flag ", cfgs}, st[1], 1'b1);
      if (ext) check({"R7 clock pin released ", cfgs}, sck_oe, 1'b0);
      else     check({"R6 half period ", cfgs}, m_t2 - m_t1, div + 1);
      if (do_read) begin
         rd(2'd2, d);
         check({"R5 R2 received word ", cfgs}, d, size_mask(wide, sw));
         rd(2'd1, st);
         check("R11 receive full cleared by read", st[0], 1'b0);
      end
   endtask

   initial begin
      logic [15:0] st, d, wa, wb;
      void'($urandom(32'h1D2C3B4A));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(2'd1, st); check("R9 status after reset", st, 16'h0);
      rd(2'd0, d);  check("R9 control after reset", d, 16'h0);
      check("R9 pins idle after reset", {sck_o, sck_oe, sdo_oe, irq_o}, 4'b0000);

      // no start while disabled or not master
      wr(2'd0, mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0, 4'd1));
      wr(2'd2, 16'hA5A5);
      repeat (40) @(negedge clk);
      rd(2'd1, st); check("R1 disabled write starts nothing", st[2:0], 3'b000);
      check("R1 clock quiet while disabled", sck_o, 1'b0);
      wr(2'd0, mk_ctrl(0, 0, 1, 0, 0, 0, 0, 0, 4'd1));
      wr(2'd1, 16'h8000);
      wr(2'd2, 16'h5A5A);
      repeat (40) @(negedge clk);
      rd(2'd1, st); check("R1 non-master write starts nothing", st[2:0], 3'b000);

      // pin release controls
      wr(2'd0, mk_ctrl(0, 1, 1, 0, 0, 0, 1, 0, 4'd1));
      check("R8 data pin released", sdo_oe, 1'b0);
      wr(2'd0, mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0, 4'd1));
      check("R8 data pin driven", sdo_oe, 1'b1);
      check("R7 clock pin driven internally", sck_oe, 1'b1);
      wr(2'd0, mk_ctrl(1, 0, 1, 0, 0, 0, 1, 0, 4'd1));
      check("R7 clock pin released in external mode", sck_oe, 1'b0);

      // every polarity / edge / sample combination, both sizes, internal clock
      for (int m = 0; m < 16; m++)
         xfer(m[0], m[1], m[2], m[3], 1'b0, 4'd1, 16'hC3A1 ^ 16'(m * 16'h1111),
              16'h3B6D ^ 16'(m * 16'h0707), 1'b0, 1'b1, 1'b0);

      // external clock, each edge / sample combination
      for (int m = 0; m < 8; m++)
         xfer(m[2], m[0], m[1], 1'b1, 1'b1, 4'd3, 16'h9E37 + 16'(m), 16'h61C8 - 16'(m),
              1'b0, 1'b1, 1'b0);
      xfer(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 16'h00B4, 16'h004B, 1'b0, 1'b1, 1'b0);

      // random mix
      for (int k = 0; k < 14; k++) begin
         logic [31:0] r;
         r = $urandom;
         xfer(r[0], r[1], r[2], r[3], (r[7:4] == 4'd0), 4'(r[10:8]),
              16'($urandom), 16'($urandom), 1'b0, 1'b1, 1'b0);
      end

      // interrupt and done flag handling
      xfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 16'h0071, 16'h00E2, 1'b1, 1'b1, 1'b0);
      check("R12 interrupt raised", irq_o, 1'b1);
      wr(2'd1, 16'h8042);
      check("R12 writing one keeps interrupt", irq_o, 1'b1);
      wr(2'd1, 16'h8040);
      check("R12 writing zero clears interrupt", irq_o, 1'b0);
      rd(2'd1, st); check("R12 done bit cleared", st[1], 1'b0);

      // overflow: two unread words
      wa = 16'h1357; wb = 16'hFDB9;
      xfer(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 16'h2468, wa, 1'b0, 1'b0, 1'b0);
      rd(2'd1, st); check("R11 receive full set", st[0], 1'b1);
      check("R10 no overflow after first word", st[6], 1'b0);
      xfer(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 16'h8642, wb, 1'b0, 1'b0, 1'b0);
      rd(2'd1, st); check("R10 overflow set", st[6], 1'b1);
      rd(2'd2, d);  check("R10 newer word discarded", d, wa);
      wr(2'd1, 16'h8040);
      rd(2'd1, st); check("R10 writing one keeps overflow", st[6], 1'b1);
      wr(2'd1, 16'h8000);
      rd(2'd1, st); check("R10 writing zero clears overflow", st[6], 1'b0);

      // write during busy ignored
      xfer(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7, 16'hBEEF, 16'h1234, 1'b0, 1'b1, 1'b1);

      // abort by disabling
      wr(2'd0, mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0, 4'd7));
      wr(2'd1, 16'h8000);
      wr(2'd2, 16'hFFFF);
      repeat (20) @(negedge clk);
      wr(2'd1, 16'h0000);
      rd(2'd1, st); check("R9 disable aborts transfer", st[2], 1'b0);
      check("R9 clock idle after abort", sck_o, 1'b0);

      summary();
   end
endmodule